// File: doc/BRIEF.md
# Selectable Multi-Shape Stimulus Generator

This block produces signed sample words for a digital-to-analog converter that drives a circuit under test. A single phase accumulator sets the rate of every waveform. Four shapes can be produced from it: a sine read from a computed table, a square pulse, a triangle, and a pseudo-random pattern from a linear feedback shift register. The selected sample is multiplied by an 8-bit gain and then registered onto a valid/ready output stream.

The shape comes from a direct select input, or, in automatic mode, from an internal sequencer. The sequencer moves to the next shape each time a measurement record completes. Whenever the active shape changes, the phase restarts at zero, so every shape starts its record from the same point.

The output register follows the usual valid/ready rules. A word is offered by raising `out_valid`. It is held unchanged, and the phase does not advance, for as long as `out_ready` is low. When `run` is low, no new words are produced. The consumer may drop `out_ready` at any time without losing a word.

Top module: `shape_stim_gen`

## Requirements
- R1: While `rst_n` is low, and at its release, `out_valid` is 0 and `out_data` is 0. The active shape is sine (code 0), the phase is 0, and the shift register holds the seed 0xACE1.
- R2: A new word is produced on a rising edge when `run` is 1 and either `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_data` hold and the phase does not move. If no word is produced and `out_ready` is 1, `out_valid` falls.
- R3: Each word is computed from the phase held before that edge. On the same edge the 32-bit phase then advances by `tuning`, modulo 2^32. The word appears on `out_data` one cycle after that phase value was held.
- R4: Sine shape (code 0) uses index i, the top 8 phase bits. With h = i mod 128 and m = floor(h*(128-h)*2047/4096), the sample is m for i < 128 and -m otherwise.
- R5: Pulse shape (code 1) gives +2047 when phase bit 31 is 0 and -2047 when it is 1.
- R6: Triangle shape (code 2) takes t = phase[30:19]. When phase bit 31 is 1, t is replaced by 4095 - t. The sample is t - 2048.
- R7: Noise shape (code 3) takes the sample from bits 15:4 of a 16-bit register, read as signed. The register starts at 0xACE1 and steps as a right-shifting Galois register with mask 0xB400. It steps only on an edge that produces a word, has a carry out of the phase addition, and has no shape change.
- R8: The word on `out_data` is floor(sample * `gain` / 256), with `gain` unsigned.
- R9: With `auto_mode` at 0, the active shape follows `shape_sel` one edge later.
- R10: With `auto_mode` at 1, `shape_sel` has no effect. Each edge with `record_done` high advances the shape through 0, 1, 2, 3 and then wraps back to 0.
- R11: On an edge where the active shape changes, the phase is set to 0 and the shift register does not step. A word produced on that edge still uses the old shape and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Allows new words to be produced |
| auto_mode | input | 1 | 1: the sequencer picks the shape; 0: `shape_sel` picks it |
| shape_sel | input | 2 | Direct shape code (0 sine, 1 pulse, 2 triangle, 3 noise) |
| record_done | input | 1 | Strobe that advances the shape in automatic mode |
| tuning | input | 32 | Phase increment per produced word |
| gain | input | 8 | Unsigned amplitude gain, 256 counts = unity |
| out_data | output | 12 | Signed sample word for the converter |
| out_valid | output | 1 | `out_data` holds a word |
| out_ready | input | 1 | Consumer accepts the word |

## Verification
A wrong phase value shows on the next produced word. With a small tuning step it shows as a sine or triangle sample that is off by one table step, or as a pulse whose sign flips at the wrong time. A shift register that steps at the wrong moment changes the noise word of the next record. A sequencer that is out of step shows on the first word after `record_done`, because that word comes from the wrong shape at phase zero. A stall fault shows at once as a word that changes, or a phase that skips, while `out_ready` is low.

// File: rtl/shape_stim_pkg.sv
package shape_stim_pkg;
  typedef enum logic [1:0] {
    SHP_SINE  = 2'd0,
    SHP_PULSE = 2'd1,
    SHP_TRI   = 2'd2,
    SHP_NOISE = 2'd3
  } shape_e;
endpackage

// File: rtl/stim_shape_seq.sv
module stim_shape_seq
  import shape_stim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_mode,
  input  logic [1:0] shape_sel,
  input  logic       record_done,
  output shape_e     shape_q,
  output logic       shape_chg
);
  shape_e shape_d;

  always_comb begin
    if (auto_mode) shape_d = record_done ? shape_e'(shape_q + 2'd1) : shape_q;
    else           shape_d = shape_e'(shape_sel);
    shape_chg = (shape_d != shape_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shape_q <= SHP_SINE;
    else        shape_q <= shape_d;
  end

  // R10
  auto_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode && record_done |=> shape_q == shape_e'(2'($past(shape_q)) + 2'd1));

  // R9
  manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> 2'(shape_q) == $past(shape_sel));
endmodule

// File: rtl/stim_phase_acc.sv
module stim_phase_acc #(
  parameter int PW = 32,
  parameter int HW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          clear,
  input  logic [PW-1:0] tuning,
  output logic [HW-1:0] phase_hi,
  output logic          carry
);
  logic [PW-1:0] phase_q;
  logic [PW:0]   sum;

  always_comb begin
    sum      = {1'b0, phase_q} + {1'b0, tuning};
    carry    = sum[PW];
    phase_hi = phase_q[PW-1 -: HW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (clear)   phase_q <= '0;
    else if (advance) phase_q <= sum[PW-1:0];
  end

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> phase_q == '0);

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !clear |=> $stable(phase_q));
endmodule

// File: rtl/stim_lfsr.sv
module stim_lfsr #(
  parameter int          LW   = 16,
  parameter int          DW   = 12,
  parameter logic [LW-1:0] MASK = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  output logic [DW-1:0] sample
);
  logic [LW-1:0] state_q;
  logic [LW-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ MASK;
    sample = state_q[LW-1 -: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= SEED;
    else if (shift) state_q <= state_d;
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R7
  lfsr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(state_q));
endmodule

// File: rtl/stim_sample_mux.sv
module stim_sample_mux
  import shape_stim_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 12,
  parameter int GW = 8
) (
  input  shape_e               shape,
  input  logic [DW:0]          phase_hi,
  input  logic [DW-1:0]        noise,
  input  logic [GW-1:0]        gain,
  output logic signed [DW-1:0] scaled
);
  localparam int HALF = 2 ** (AW - 1);
  localparam int QTR  = HALF / 2;
  localparam int FS   = 2 ** (DW - 1) - 1;
  localparam int DEPTH = 2 ** AW;

  function automatic logic signed [DW-1:0] sine_entry(input int idx);
    int h;
    int m;
    h = idx % HALF;
    m = (h * (HALF - h) * FS) / (QTR * QTR);
    return (idx >= HALF) ? DW'(-m) : DW'(m);
  endfunction

  logic signed [DW-1:0] rom [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = sine_entry(i);
  end

  logic [AW-1:0]        idx;
  logic [DW-1:0]        fold;
  logic signed [DW-1:0] pick;
  logic signed [DW+GW-1:0] prod;

  always_comb begin
    idx  = phase_hi[DW -: AW];
    fold = phase_hi[DW] ? ~phase_hi[DW-1:0] : phase_hi[DW-1:0];
    pick = '0;
    case (shape)
      SHP_SINE:  pick = rom[idx];
      SHP_PULSE: pick = phase_hi[DW] ? DW'(-FS) : DW'(FS);
      SHP_TRI:   pick = {~fold[DW-1], fold[DW-2:0]};
      SHP_NOISE: pick = noise;
      default:   pick = '0;
    endcase
    prod   = pick * $signed({1'b0, gain});
    scaled = DW'(prod >>> GW);
  end
endmodule

// File: rtl/shape_stim_gen.sv
module shape_stim_gen
  import shape_stim_pkg::*;
#(
  parameter int PW = 32,
  parameter int AW = 8,
  parameter int DW = 12,
  parameter int GW = 8,
  parameter int LW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 auto_mode,
  input  logic [1:0]           shape_sel,
  input  logic                 record_done,
  input  logic [PW-1:0]        tuning,
  input  logic [GW-1:0]        gain,
  output logic signed [DW-1:0] out_data,
  output logic                 out_valid,
  input  logic                 out_ready
);
  localparam int HW = DW + 1;

  shape_e               shape_q;
  logic                 shape_chg;
  logic                 step;
  logic                 carry;
  logic [HW-1:0]        phase_hi;
  logic [DW-1:0]        noise;
  logic signed [DW-1:0] scaled;

  assign step = run && (!out_valid || out_ready);

  stim_shape_seq u_seq (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .shape_sel(shape_sel),
    .record_done(record_done), .shape_q(shape_q), .shape_chg(shape_chg)
  );

  stim_phase_acc #(.PW(PW), .HW(HW)) u_acc (
    .clk(clk), .rst_n(rst_n), .advance(step), .clear(shape_chg),
    .tuning(tuning), .phase_hi(phase_hi), .carry(carry)
  );

  stim_lfsr #(.LW(LW), .DW(DW)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .shift(step && carry && !shape_chg), .sample(noise)
  );

  stim_sample_mux #(.AW(AW), .DW(DW), .GW(GW)) u_mux (
    .shape(shape_q), .phase_hi(phase_hi), .noise(noise), .gain(gain), .scaled(scaled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (step) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && out_ready |=> !out_valid);
endmodule

// File: tb/shape_stim_gen_test.sv
module shape_stim_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        auto_mode = 1'b0;
  logic [1:0]  shape_sel = 2'd0;
  logic        record_done = 1'b0;
  logic [31:0] tuning = 32'd0;
  logic [7:0]  gain = 8'd255;
  logic signed [11:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;

  int total = 0;
  int passed = 0;
  string req = "R1";

  int        m_shape = 0;
  longint    m_ph = 0;
  int        m_lf = 16'hACE1;
  bit        m_valid = 1'b0;
  int        m_data = 0;

  always #2.5 clk = ~clk;

  shape_stim_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run), .auto_mode(auto_mode),
    .shape_sel(shape_sel), .record_done(record_done), .tuning(tuning),
    .gain(gain), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
  endtask

  function automatic int sine_ref(input int i);
    int h = i % 128;
    int m = (h * (128 - h) * 2047) / 4096;
    return (i >= 128) ? -m : m;
  endfunction

  function automatic int sample_ref(input int shp, input longint ph, input int lf);
    int t;
    case (shp)
      0: return sine_ref(int'((ph >> 24) & 255));
      1: return ((ph >> 31) & 1) != 0 ? -2047 : 2047;
      2: begin
        t = int'((ph >> 19) & 4095);
        if (((ph >> 31) & 1) != 0) t = 4095 - t;
        return t - 2048;
      end
      default: begin
        t = (lf >> 4) & 4095;
        return (t >= 2048) ? t - 4096 : t;
      end
    endcase
  endfunction

  function automatic int lfsr_next(input int lf);
    int n = lf >> 1;
    if ((lf & 1) != 0) n = n ^ 16'hB400;
    return n;
  endfunction

  task automatic cyc();
    bit     st;
    int     nshape;
    longint sum;
    st = run && (!m_valid || out_ready);
    if (auto_mode) nshape = record_done ? (m_shape + 1) % 4 : m_shape;
    else           nshape = int'(shape_sel);
    if (st) begin
      m_data  = (sample_ref(m_shape, m_ph, m_lf) * int'(gain)) >>> 8;
      m_valid = 1'b1;
    end else if (out_ready) begin
      m_valid = 1'b0;
    end
    if (nshape != m_shape) begin
      m_ph = 0;
    end else if (st) begin
      sum = m_ph + longint'(tuning);
      if (sum >= 64'h1_0000_0000) m_lf = lfsr_next(m_lf);
      m_ph = sum & 64'hFFFF_FFFF;
    end
    m_shape = nshape;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == m_valid, req, int'(out_valid), int'(m_valid));
    if (m_valid) check(int'(out_data) == m_data, req, int'(out_data), m_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_data == 12'sd0, "R1", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);

    // R4 / R3: every sine table entry, one per word
    req = "R4"; run = 1'b1; tuning = 32'h0100_0000; gain = 8'd255;
    for (int i = 0; i < 260; i++) cyc();

    // R5 / R11: switch to pulse while running
    req = "R5"; shape_sel = 2'd1; tuning = 32'h0500_0000;
    for (int i = 0; i < 200; i++) cyc();

    // R6: every triangle code over a full period
    req = "R6"; shape_sel = 2'd2; tuning = 32'h0008_0000;
    for (int i = 0; i < 8200; i++) cyc();

    // R7: noise with a carry every second word
    req = "R7"; shape_sel = 2'd3; tuning = 32'h8000_0000; gain = 8'd200;
    for (int i = 0; i < 600; i++) cyc();
    // R7: odd step, carries on irregular words
    tuning = 32'h6000_0001;
    for (int i = 0; i < 300; i++) cyc();

    // R8: every gain value on the sine shape
    req = "R8"; shape_sel = 2'd0; tuning = 32'h0300_0000;
    for (int i = 0; i < 256; i++) begin gain = 8'(i); cyc(); end
    shape_sel = 2'd1;
    for (int i = 0; i < 256; i++) begin gain = 8'(i); cyc(); end

    // R2: back-pressure and run gaps
    req = "R2"; shape_sel = 2'd2; tuning = 32'h0123_4567; gain = 8'd255;
    for (int i = 0; i < 300; i++) begin
      out_ready = (i % 3) != 0;
      run = (i % 7) != 0;
      cyc();
    end
    out_ready = 1'b1; run = 1'b1;

    // R9: direct shape changes, including with run low (R11)
    req = "R9";
    for (int k = 0; k < 8; k++) begin
      shape_sel = 2'((k * 3) % 4);
      run = (k % 2) == 0;
      for (int i = 0; i < 20; i++) cyc();
    end
    run = 1'b1;

    // R10: automatic sequencing, shape_sel ignored
    req = "R10"; auto_mode = 1'b1; tuning = 32'h0400_0000;
    for (int k = 0; k < 10; k++) begin
      shape_sel = 2'(k);
      for (int i = 0; i < 30; i++) cyc();
      record_done = 1'b1; cyc();
      record_done = 1'b0;
    end
    // R10: back-to-back strobes
    record_done = 1'b1;
    for (int i = 0; i < 6; i++) cyc();
    record_done = 1'b0;
    for (int i = 0; i < 20; i++) cyc();

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule